// File: doc/BRIEF.md
# Serial Delta-RGB Pixel Serializer

This block takes a stream of 24-bit RGB pixels and sends each one over an 8-bit panel bus as three consecutive bytes, one colour component per dot-clock tick. A panel fed this way needs all of its horizontal timing counted in dot-clock ticks, so each pixel takes three ticks. The order of the three components is programmable. A separate order can be chosen for odd lines and for even lines. This is how delta-RGB panels are driven: odd lines go out red-green-blue, and even lines go out green-blue-red.

Pixels enter through a valid/ready handshake. Each pixel carries start-of-line and start-of-frame flags. An 8-bit control word sets the two line-parity orders. Software writes it through a small write port at one fixed address, and the block latches it at each start of frame. On the output side there is the byte bus, a data-enable, and one-tick line and frame sync pulses that line up with the first byte of a flagged pixel.

Top module: `drgb_serializer`

## Requirements
- R1: Each accepted pixel (red in bits [23:16], green in [15:8], blue in [7:0]) produces exactly three bus bytes on consecutive ticks, one component per tick.
- R2: The order code selects the component sequence: 0 red-green-blue, 1 red-blue-green, 2 green-red-blue, 3 green-blue-red, 4 blue-red-green, 5 blue-green-red.
- R3: A write to address 0x90 stores bits [6:4] of the write data as the odd-line code and bits [2:0] as the even-line code. A write to any other address has no effect. Both codes are 0 after reset.
- R4: With the control word 0x03, odd lines are sent red-green-blue and even lines green-blue-red.
- R5: A pixel flagged start-of-frame begins line 1, which is odd. Each later pixel flagged start-of-line toggles the parity.
- R6: Codes 6 and 7 are sent as red-green-blue.
- R7: Both codes are captured when a start-of-frame pixel is accepted. A write made in the middle of a frame changes nothing until the next frame.
- R8: pix_ready is high only when the block is idle or on the third byte of a pixel. Pixels offered back to back leave no gap in lcd_de, and lcd_de stays high for all three bytes.
- R9: When no pixel is available, lcd_de is low and lcd_data, lcd_hsync and lcd_vsync are all zero.
- R10: lcd_hsync pulses on the first byte of a pixel flagged start-of-line or start-of-frame. lcd_vsync pulses on the first byte of a pixel flagged start-of-frame.
- R11: The first byte of a pixel appears on the tick after the pixel is accepted.
- R12: After reset, lcd_de is low, lcd_data is zero and pix_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 8 | Control write address |
| cfg_wdata | input | 8 | Control write data (odd code [6:4], even code [2:0]) |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 24 | Pixel, red [23:16], green [15:8], blue [7:0] |
| pix_sol | input | 1 | Pixel starts a line |
| pix_sof | input | 1 | Pixel starts a frame |
| pix_ready | output | 1 | Pixel accepted this tick when valid |
| lcd_data | output | 8 | Panel byte bus |
| lcd_de | output | 1 | Panel data enable |
| lcd_hsync | output | 1 | Line sync pulse |
| lcd_vsync | output | 1 | Frame sync pulse |

## Verification
The bench sweeps all 64 pairs of odd and even codes over frames of several lines. This catches a swapped field, a wrong permutation entry, or a reserved code that is not sent as red-green-blue. Any of those would put a component in the wrong byte slot. A control write in mid-frame checks that the codes are latched, and a design that applied the write at once would reorder bytes in the middle of a frame. Back-to-back bursts and starved gaps look for a dropped data-enable between pixels and for stale bytes left on the bus while idle. The parity tests catch a design that starts frames on an even line or forgets to toggle on start-of-line.

// File: rtl/drgb_pkg.sv
package drgb_pkg;
  localparam int CODE_W   = 3;
  localparam int CFG_W    = 8;
  localparam int ODD_LSB  = 4;
  localparam int EVEN_LSB = 0;
  localparam int N_COMP   = 3;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [1:0]        slot_t;

  // Component index per beat: 0 red, 1 green, 2 blue.
  function automatic slot_t slot_of(input code_t code, input slot_t beat);
    slot_t s0, s1, s2;
    case (code)
      3'd1:    begin s0 = 2'd0; s1 = 2'd2; s2 = 2'd1; end
      3'd2:    begin s0 = 2'd1; s1 = 2'd0; s2 = 2'd2; end
      3'd3:    begin s0 = 2'd1; s1 = 2'd2; s2 = 2'd0; end
      3'd4:    begin s0 = 2'd2; s1 = 2'd0; s2 = 2'd1; end
      3'd5:    begin s0 = 2'd2; s1 = 2'd1; s2 = 2'd0; end
      default: begin s0 = 2'd0; s1 = 2'd1; s2 = 2'd2; end
    endcase
    case (beat)
      2'd0:    slot_of = s0;
      2'd1:    slot_of = s1;
      default: slot_of = s2;
    endcase
  endfunction

  // Reserved codes fold onto the plain order.
  function automatic code_t legal_code(input code_t code);
    legal_code = (code > 3'd5) ? 3'd0 : code;
  endfunction
endpackage

// File: rtl/drgb_order_reg.sv
module drgb_order_reg
  import drgb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output code_t             odd_code,
  output code_t             even_code
);
  logic  hit;
  code_t odd_q, even_q;

  assign hit = we && (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (hit) begin
      odd_q  <= wdata[ODD_LSB +: CODE_W];
      even_q <= wdata[EVEN_LSB +: CODE_W];
    end
  end

  assign odd_code  = odd_q;
  assign even_code = even_q;

  // R3: foreign addresses leave the codes alone
  a_r3_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != REG_ADDR) |=> ($stable(odd_q) && $stable(even_q)));
endmodule

// File: rtl/drgb_line_ctx.sv
module drgb_line_ctx
  import drgb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc,
  input  logic  sol,
  input  logic  sof,
  input  code_t odd_code,
  input  code_t even_code,
  output code_t pix_code,
  output logic  line_odd
);
  logic  odd_q;
  code_t odd_lat_q, even_lat_q;
  logic  eff_odd;
  code_t eff_odd_code, eff_even_code;

  always_comb begin
    if (sof) begin
      eff_odd       = 1'b1;
      eff_odd_code  = odd_code;
      eff_even_code = even_code;
    end else begin
      eff_odd       = sol ? ~odd_q : odd_q;
      eff_odd_code  = odd_lat_q;
      eff_even_code = even_lat_q;
    end
    pix_code = legal_code(eff_odd ? eff_odd_code : eff_even_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q      <= 1'b1;
      odd_lat_q  <= '0;
      even_lat_q <= '0;
    end else if (acc) begin
      odd_q <= eff_odd;
      if (sof) begin
        odd_lat_q  <= odd_code;
        even_lat_q <= even_code;
      end
    end
  end

  assign line_odd = odd_q;

  // R5: a frame starts on an odd line
  a_r5_frame_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sof) |=> line_odd);
  // R5: start-of-line flips parity
  a_r5_line_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sol && !sof) |=> (line_odd != $past(line_odd)));
  // R5: plain pixels keep parity
  a_r5_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && (sol || sof)) |=> $stable(line_odd));
  // R7: codes latched only at frame start
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && sof) |=> ($stable(odd_lat_q) && $stable(even_lat_q)));
endmodule

// File: rtl/drgb_beat_engine.sv
module drgb_beat_engine
  import drgb_pkg::*;
#(
  parameter int COMP_W = 8,
  localparam int PIX_W = N_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_sol,
  input  logic              pix_sof,
  input  code_t             code_in,
  output logic              pix_ready,
  output logic              acc,
  output logic [COMP_W-1:0] bus_data,
  output logic              bus_de,
  output logic              bus_hsync,
  output logic              bus_vsync
);
  localparam slot_t LAST_BEAT = slot_t'(N_COMP - 1);

  logic              active_q;
  slot_t             beat_q;
  logic [PIX_W-1:0]  pix_q;
  code_t             code_q;
  logic [COMP_W-1:0] data_q;
  logic              hs_q, vs_q;
  logic              beat_last;

  function automatic logic [COMP_W-1:0] comp_of(input logic [PIX_W-1:0] px,
                                                input slot_t idx);
    comp_of = px[PIX_W - 1 - COMP_W * int'(idx) -: COMP_W];
  endfunction

  assign beat_last = (beat_q == LAST_BEAT);
  assign pix_ready = !active_q || beat_last;
  assign acc       = pix_valid && pix_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      pix_q    <= '0;
      code_q   <= '0;
      data_q   <= '0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
    end else if (acc) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      pix_q    <= pix_data;
      code_q   <= code_in;
      data_q   <= comp_of(pix_data, slot_of(code_in, 2'd0));
      hs_q     <= pix_sol || pix_sof;
      vs_q     <= pix_sof;
    end else if (active_q && !beat_last) begin
      beat_q <= beat_q + 2'd1;
      data_q <= comp_of(pix_q, slot_of(code_q, beat_q + 2'd1));
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
    end else begin
      active_q <= 1'b0;
      beat_q   <= '0;
      data_q   <= '0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
    end
  end

  assign bus_data  = data_q;
  assign bus_de    = active_q;
  assign bus_hsync = hs_q;
  assign bus_vsync = vs_q;

  // R8: data-enable holds for three beats after acceptance
  a_r8_three_beats: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> bus_de ##1 bus_de ##1 bus_de);
  // R8: no new pixel while mid-pixel
  a_r8_no_early_take: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_de && !beat_last) |-> !acc);
  // R9: idle bus carries zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_de |-> (bus_data == '0 && !bus_hsync && !bus_vsync));
  // R10: frame sync implies line sync inside an enabled beat
  a_r10_sync_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vsync |-> bus_hsync) and (bus_hsync |-> bus_de));
  // R11: line sync follows the accepted flags one tick later
  a_r11_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (bus_hsync == ($past(pix_sol) || $past(pix_sof))));
  // R6: only legal codes reach the beat engine
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_de |-> (code_q <= 3'd5));
endmodule

// File: rtl/drgb_serializer.sv
module drgb_serializer
  import drgb_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h90,
  localparam int PIX_W = N_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_sol,
  input  logic              pix_sof,
  output logic              pix_ready,
  output logic [COMP_W-1:0] lcd_data,
  output logic              lcd_de,
  output logic              lcd_hsync,
  output logic              lcd_vsync
);
  code_t odd_code, even_code, pix_code;
  logic  acc, line_odd;

  drgb_order_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .odd_code(odd_code), .even_code(even_code)
  );

  drgb_line_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sol(pix_sol), .sof(pix_sof),
    .odd_code(odd_code), .even_code(even_code),
    .pix_code(pix_code), .line_odd(line_odd)
  );

  drgb_beat_engine #(.COMP_W(COMP_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sol(pix_sol), .pix_sof(pix_sof), .code_in(pix_code),
    .pix_ready(pix_ready), .acc(acc), .bus_data(lcd_data), .bus_de(lcd_de),
    .bus_hsync(lcd_hsync), .bus_vsync(lcd_vsync)
  );

  // R12: reset leaves the bus quiet and the input open
  a_r12_post_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!lcd_de && lcd_data == '0 && pix_ready));
  // R5: parity is odd right after each frame-start pixel
  a_r5_top_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_vsync) |-> line_odd);
endmodule

// File: tb/drgb_serializer_tb_top.sv
module drgb_serializer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_sol = 1'b0;
  logic        pix_sof = 1'b0;
  logic        pix_ready;
  logic [7:0]  lcd_data;
  logic        lcd_de, lcd_hsync, lcd_vsync;

  always #(CLK_PERIOD/2) clk = ~clk;

  drgb_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sol(pix_sol), .pix_sof(pix_sof), .pix_ready(pix_ready),
    .lcd_data(lcd_data), .lcd_de(lcd_de), .lcd_hsync(lcd_hsync),
    .lcd_vsync(lcd_vsync)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [9:0] exp_q[$];
  logic [5:0] reg_m = '0;
  logic [5:0] lat_m = '0;
  logic       odd_m = 1'b1;
  bit         mon_en = 1'b0;
  int         first_de = -1;
  int         last_de  = -1;
  int         beat_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: first component is code/2, remaining two ascending, swapped on odd codes
  function automatic logic [7:0] ref_byte(input logic [23:0] px, input int code, input int beat);
    int first, lo, hi, idx;
    first = code / 2;
    lo = (first == 0) ? 1 : 0;
    hi = (first == 2) ? 1 : 2;
    if (beat == 0) idx = first;
    else if (beat == 1) idx = (code % 2 == 1) ? hi : lo;
    else idx = (code % 2 == 1) ? lo : hi;
    return px[23 - 8*idx -: 8];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (lcd_de) begin
        logic [9:0] e;
        beat_cnt++;
        if (first_de < 0) first_de = cyc;
        last_de = cyc;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected beat", lcd_data, 0);
        end else begin
          e = exp_q.pop_front();
          check(lcd_data == e[7:0], "R1 R2 byte", lcd_data, e[7:0]);
          check(lcd_hsync == e[8], "R10 hsync", lcd_hsync, e[8]);
          check(lcd_vsync == e[9], "R10 vsync", lcd_vsync, e[9]);
        end
      end else begin
        check(lcd_data == 8'h00 && !lcd_hsync && !lcd_vsync, "R9 idle bus",
              {lcd_vsync, lcd_hsync, lcd_data}, 0);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'h90) reg_m = {d[6:4], d[2:0]};
  endtask

  task automatic send(input logic [23:0] px, input bit sol, input bit sof);
    int code;
    pix_valid = 1'b1; pix_data = px; pix_sol = sol; pix_sof = sof;
    while (!pix_ready) @(negedge clk);
    if (sof) begin lat_m = reg_m; odd_m = 1'b1; end
    else if (sol) odd_m = ~odd_m;
    code = odd_m ? int'(lat_m[5:3]) : int'(lat_m[2:0]);
    if (code > 5) code = 0;                       // R6
    for (int b = 0; b < 3; b++)
      exp_q.push_back({(b == 0) && sof, (b == 0) && (sol || sof), ref_byte(px, code, b)});
    @(negedge clk);
    check(lcd_de == 1'b1, "R11 first beat latency", lcd_de, 1);
    pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
  endtask

  task automatic idle(input int n);
    pix_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mkpix(input int i);
    return {8'h10 + 8'(i), 8'h80 + 8'(i), 8'hE0 ^ 8'(i)};
  endfunction

  task automatic frame(input int lines, input int ppl, input int seed);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < ppl; p++)
        send(mkpix(seed + l*ppl + p), (p == 0), (l == 0 && p == 0));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(!lcd_de && lcd_data == 8'h00 && pix_ready, "R12 reset state",
          {lcd_de, pix_ready, lcd_data}, 10'h100);
    mon_en = 1'b1;

    // R3: reset codes give plain order on both parities
    frame(2, 2, 0); idle(3);

    // R4: delta mode
    wr(8'h90, 8'h03); frame(4, 2, 10); idle(3);

    // R3: write elsewhere is ignored (output still delta from 0x03)
    wr(8'h91, 8'h55); frame(2, 2, 20); idle(2);

    // R7: mid-frame write only lands next frame
    wr(8'h90, 8'h00);
    send(mkpix(30), 1, 1); send(mkpix(31), 0, 0);
    wr(8'h90, 8'h54);
    send(mkpix(32), 1, 0); send(mkpix(33), 0, 0);
    idle(2);
    frame(2, 2, 34); idle(2);

    // R8: back-to-back burst has no gap
    wr(8'h90, 8'h21);
    idle(2);
    first_de = -1; last_de = -1; beat_cnt = 0;
    send(mkpix(40), 1, 1); send(mkpix(41), 0, 0);
    send(mkpix(42), 1, 0); send(mkpix(43), 0, 0);
    idle(4);
    check(last_de - first_de == 11, "R8 burst span", last_de - first_de, 11);
    check(beat_cnt == 12, "R8 burst beats", beat_cnt, 12);

    // R9: starved stream between pixels
    send(mkpix(50), 1, 1); idle(5); send(mkpix(51), 0, 0); idle(3);

    // R2 R6: sweep all odd/even code pairs, including reserved 6 and 7
    for (int o = 0; o < 8; o++)
      for (int e = 0; e < 8; e++) begin
        wr(8'h90, 8'((o << 4) | e));
        frame(3, 2, o*8 + e);
        idle(1);
      end
    idle(4);
    check(exp_q.size() == 0, "R1 all beats emitted", exp_q.size(), 0);
    finish_run();
  end
endmodule